// File: doc/BRIEF.md
# Programmable Pipeline Stream Delay

This block lines up one data stream with another by holding each word back for a fixed number of clock cycles, from 0 to 15. The words go into a 16-entry register array that has one write port and one read port. A controller steps the write pointer and the read pointer. The delay is sampled on a one-cycle start pulse, and capture begins on the following cycle. A stop input ends capture. The block then keeps reading until every word it holds has reached the output, and it returns to idle.

On start, the read pointer is loaded with the delay value and serves as a countdown timer. It counts down to its last step, then turns into the read address and counts up. The read port is registered, and one write-to-read forwarding path covers a delay of one. A delay of zero sends the input word straight to the output.

Top module: `stream_delay`

## Requirements
- R1: After reset, `dout_vld` is 0 and the block is idle until a start pulse arrives.
- R2: With a delay D from 1 to 15 sampled at start in cycle 0, the word presented in cycle 1+j is on `dout` in cycle 1+j+D with `dout_vld` high.
- R3: With D = 0, `dout` equals `din` in the same cycle, and `dout_vld` is high on every capture cycle.
- R4: The first captured word is the one on `din` in the cycle after start. Whatever is on `din` during the start cycle is never output.
- R5: A stop sampled high during capture ends capture. The word in that cycle and all later words are not output. Every word captured before the stop is still output in order.
- R6: For N captured words, `dout_vld` is high for exactly N consecutive cycles and low in every other cycle of the run.
- R7: A start pulse while a run is in progress is ignored. The delay and the output timing of the current run do not change.
- R8: Stop has no effect while idle. A stop in the first capture cycle yields no output at all.
- R9: The pointers wrap modulo 16, so streams longer than 16 words stay exact at the largest delay.
- R10: After the last word has been output, the block is idle again and accepts a new start with a new delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that samples `dly` and opens capture |
| stop | input | 1 | Ends capture; stored words then drain |
| dly | input | 4 | Delay in clock cycles, 0 to 15 |
| din | input | 4 | Input data word |
| dout | output | 4 | Delayed data word |
| dout_vld | output | 1 | High when `dout` carries a delayed word |

## Verification
Let the start cycle be cycle 0. A word presented in cycle 1+j is due on the output in cycle 1+j+D. The bench computes that index with its own function and compares every cycle of a run against it, including the cycles where valid must be low. Inputs change at the falling edge, and outputs are read one nanosecond later. Registered results and the zero-delay combinational bypass therefore both settle before they are read. Each run lasts long enough to cover the whole drain and the return to idle, so late or extra valid cycles are caught.

// File: rtl/sd_pkg.sv
package sd_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_COUNT  = 2'd1,
    PH_STREAM = 2'd2
  } sd_phase_t;

  // Pointer step with natural wrap at the pointer width.
  function automatic logic [3:0] ptr_step(input logic [3:0] p, input logic up);
    return up ? p + 4'd1 : p - 4'd1;
  endfunction

  // Occupancy update: one word in, one word out per cycle at most.
  function automatic logic [4:0] occ_next(input logic [4:0] occ, input logic push,
                                          input logic pop);
    return occ + {4'd0, push} - {4'd0, pop};
  endfunction
endpackage

// File: rtl/sd_regfile.sv
module sd_regfile #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          rd_en,
  input  logic [AW-1:0] raddr,
  input  logic          fwd,
  output logic [DW-1:0] rdata_q,
  output logic          rvld_q
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= rd_en;
      if (rd_en) rdata_q <= fwd ? wdata : mem[raddr];
    end
  end

  // The controller may only forward when it writes the very slot it reads.
  assert_fwd_same_slot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |-> (wr_en && rd_en && waddr == raddr));
  // A read from the array itself must never collide with the write in the same cycle.
  assert_no_port_clash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !fwd && wr_en) |-> (waddr != raddr));
endmodule

// File: rtl/sd_ctrl.sv
module sd_ctrl
  import sd_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] dly,
  output logic          wr_en,
  output logic [AW-1:0] waddr,
  output logic          rd_en,
  output logic [AW-1:0] raddr,
  output logic          fwd,
  output logic          byp_mode,
  output logic          byp_vld
);
  localparam int OW = AW + 1;

  sd_phase_t     phase;
  logic [AW-1:0] rp, wp, dly_q;
  logic [OW-1:0] occ;
  logic          cap;
  logic          cap_live, occ_any, timer_last;

  assign cap_live   = cap && !stop;
  assign byp_mode   = (dly_q == '0);
  assign wr_en      = cap_live && !byp_mode;
  assign occ_any    = (occ != '0);
  assign timer_last = (rp == AW'(1));
  assign waddr      = wp;
  assign raddr      = (phase == PH_COUNT) ? '0 : rp;
  assign byp_vld    = cap_live && byp_mode && (phase == PH_STREAM);

  always_comb begin
    unique case (phase)
      PH_COUNT:  rd_en = timer_last && (occ_any || wr_en);
      PH_STREAM: rd_en = !byp_mode && (occ_any || wr_en);
      default:   rd_en = 1'b0;
    endcase
  end
  assign fwd = rd_en && !occ_any;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      rp    <= '0;
      wp    <= '0;
      dly_q <= '0;
      occ   <= '0;
      cap   <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            dly_q <= dly;
            rp    <= dly;
            wp    <= '0;
            occ   <= '0;
            cap   <= 1'b1;
            phase <= (dly == '0) ? PH_STREAM : PH_COUNT;
          end
        end
        PH_COUNT: begin
          cap <= cap_live;
          occ <= occ_next(occ, wr_en, rd_en);
          if (wr_en) wp <= ptr_step(wp, 1'b1);
          if (timer_last) begin
            // Timer expires: address 0 is read now, next read uses 1.
            if (rd_en) phase <= PH_STREAM;
            else begin
              phase <= PH_IDLE;
              cap   <= 1'b0;
            end
          end else begin
            rp <= ptr_step(rp, 1'b0);
          end
        end
        PH_STREAM: begin
          cap <= cap_live;
          if (byp_mode) begin
            if (!cap_live) phase <= PH_IDLE;
          end else begin
            occ <= occ_next(occ, wr_en, rd_en);
            if (wr_en) wp <= ptr_step(wp, 1'b1);
            if (rd_en) rp <= ptr_step(rp, 1'b1);
            else phase <= PH_IDLE;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // Words held never exceed the programmed delay, so 16 slots suffice.
  assert_occ_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |-> (occ <= OW'(dly_q)));
  // The delay is frozen while a run is active.
  assert_hold_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_IDLE) |=> $stable(dly_q));
  // Once stop is seen during capture, capture stays closed.
  assert_stop_closes_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && stop) |=> !cap);
  // Idle moves no data.
  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IDLE) |-> (!rd_en && !wr_en && !cap));
endmodule

// File: rtl/stream_delay.sv
module stream_delay #(
  parameter int DW = 4,
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic [AW-1:0] dly,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] dout,
  output logic          dout_vld
);
  logic          wr_en, rd_en, fwd, byp_mode, byp_vld, rvld_q;
  logic [AW-1:0] waddr, raddr;
  logic [DW-1:0] rdata_q;

  sd_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .dly(dly),
    .wr_en(wr_en), .waddr(waddr), .rd_en(rd_en), .raddr(raddr), .fwd(fwd),
    .byp_mode(byp_mode), .byp_vld(byp_vld)
  );

  sd_regfile #(.DW(DW), .AW(AW)) u_rf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .waddr(waddr), .wdata(din),
    .rd_en(rd_en), .raddr(raddr), .fwd(fwd), .rdata_q(rdata_q), .rvld_q(rvld_q)
  );

  assign dout     = byp_mode ? din : rdata_q;
  assign dout_vld = byp_mode ? byp_vld : rvld_q;

  // Every registered output word is preceded by a read issued one cycle earlier.
  assert_read_then_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvld_q);
  // The bypass path and the array path are never active together.
  assert_single_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(byp_vld && rd_en));
endmodule

// File: tb/stream_delay_bench.sv
module stream_delay_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0, stop = 1'b0;
  logic [3:0] dly = '0, din = '0;
  logic [3:0] dout;
  logic       dout_vld;
  int         n_chk = 0, n_bad = 0;
  logic [3:0] words [64];

  always #2 clk = ~clk;

  stream_delay u_stream_delay (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .dly(dly),
    .din(din), .dout(dout), .dout_vld(dout_vld)
  );

  // Index of the captured word due in cycle m (start = cycle 0).
  function automatic int due_index(int m, int d);
    return m - 1 - d;
  endfunction

  task automatic check_bit(string tag, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s dout_vld act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic check_word(string tag, logic [3:0] act, logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s dout act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // One complete run: start in cycle 0, n words, stop in cycle n+1.
  task automatic run_stream(string tag, int d, int n, bit poke_start);
    for (int i = 0; i < n; i++) words[i] = 4'($urandom);
    for (int m = 0; m <= n + d + 4; m++) begin
      @(negedge clk);
      start = (m == 0) || (poke_start && m == 3);
      dly   = (m == 0) ? 4'(d) : ~4'(d);
      stop  = (m == n + 1);
      din   = (m >= 1 && m <= n) ? words[m-1] : 4'($urandom);
      #1;
      begin
        int k;
        k = due_index(m, d);
        if (k >= 0 && k < n) begin
          check_bit(tag, dout_vld, 1'b1);
          check_word(tag, dout, words[k]);
        end else begin
          check_bit(tag, dout_vld, 1'b0);
        end
      end
    end
    @(negedge clk);
    start = 1'b0; stop = 1'b0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    #1 check_bit("R1 reset", dout_vld, 1'b0);
    @(negedge clk) rst_n = 1'b1;
    #1 check_bit("R1 idle", dout_vld, 1'b0);
    // R8: stop while idle does nothing
    @(negedge clk) stop = 1'b1;
    #1 check_bit("R8 idle stop", dout_vld, 1'b0);
    @(negedge clk) stop = 1'b0;
    #1 check_bit("R8 idle stop", dout_vld, 1'b0);

    run_stream("R3 zero delay", 0, 10, 1'b0);
    run_stream("R2 delay one", 1, 8, 1'b0);
    run_stream("R2 delay two", 2, 12, 1'b0);
    run_stream("R4 first word", 5, 1, 1'b0);
    run_stream("R8 stop first cycle", 7, 0, 1'b0);
    run_stream("R8 stop first cycle d0", 0, 0, 1'b0);
    run_stream("R9 wrap max delay", 15, 40, 1'b0);
    run_stream("R7 start ignored", 6, 10, 1'b1);
    run_stream("R7 start ignored d0", 0, 10, 1'b1);
    run_stream("R5 stop drains", 15, 5, 1'b0);
    for (int r = 0; r < 20; r++) begin
      int d, n;
      d = int'($urandom_range(15, 0));
      n = int'($urandom_range(30, 0));
      run_stream("R6 random", d, n, r[0]);
    end
    // R10: back-to-back runs with new delays
    run_stream("R10 restart", 3, 4, 1'b0);
    run_stream("R10 restart", 9, 20, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule